// File: doc/BRIEF.md
# Voltage-Frequency Transition Sequencer

This block moves a core from its present operating point, a clock ratio paired with a regulator voltage code, to a new goal point. It orders the two steps by direction. When the ratio rises, the voltage is raised first. When the ratio falls, the clock is slowed first. Each step is a request/acknowledge handshake: one with a voltage regulator, one with a clock generator. Instruction execution is stalled only while a clock step is outstanding.

The goal point comes from two sources. One is a software performance request, which is the normal operating point. The other is a thermally resolved target, which counts while the thermal flag is high. While the flag is high, the thermal ratio is floored at a lowest-frequency ratio. A software request that is not above that floored thermal ratio is obeyed directly. A software request that is above it is held back, and the thermal point is used instead. The held request takes effect once the flag drops.

The goal is sampled into a sequence latch when a sequence starts. Changes to the goal during a sequence are picked up after it ends.

Top module: `vf_step_sequencer`

## Requirements
- R1: When the goal ratio is above the current ratio, the clock step is requested only after the current voltage code already equals the goal voltage code.
- R2: When the goal ratio is below the current ratio, the voltage step is requested only after the current ratio has reached the goal ratio. At every voltage step the current ratio is at most the sequence ratio.
- R3: `exec_halt` is 1 exactly while a clock step is requested, and 0 during voltage steps and idle.
- R4: A step request stays asserted, and the current point is unchanged, until the matching acknowledge is sampled. On that acknowledge the current ratio or voltage code takes the requested value.
- R5: While `thermal_active` is 1, a software ratio above the floored thermal ratio is deferred. The core settles at the thermal point, and `status` reads 3 when idle.
- R6: While `thermal_active` is 1, a software ratio at or below the floored thermal ratio is applied. The core settles at the software point, and `status` reads 0 when idle.
- R7: When `thermal_active` falls, the core returns to the last software point.
- R8: Under thermal control, a thermal ratio below `LFM_RATIO` is raised to `LFM_RATIO` before use.
- R9: The sequence target (`clk_ratio`, `vr_code`) stays fixed while a sequence is in progress. A goal changed mid-sequence is reached only after the current sequence completes.
- R10: `status` encodes 0 = idle, 1 = voltage step, 2 = clock step, 3 = idle with a deferred software request.
- R11: After reset the current point is `RST_RATIO`/`RST_VCODE`, no request is asserted, and `status` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| thermal_active | input | 1 | Thermal control in force |
| thr_valid | input | 1 | Load a new thermal target |
| thr_ratio | input | RATIO_W | Thermal target ratio |
| thr_vcode | input | VCODE_W | Thermal target voltage code |
| sw_valid | input | 1 | Load a new software request |
| sw_ratio | input | RATIO_W | Software requested ratio |
| sw_vcode | input | VCODE_W | Software requested voltage code |
| vr_req | output | 1 | Voltage step request |
| vr_code | output | VCODE_W | Sequence voltage code |
| vr_ack | input | 1 | Regulator acknowledge |
| clk_req | output | 1 | Clock step request |
| clk_ratio | output | RATIO_W | Sequence ratio |
| clk_ack | input | 1 | Clock generator acknowledge |
| exec_halt | output | 1 | Stall instruction execution |
| cur_ratio | output | RATIO_W | Current ratio |
| cur_vcode | output | VCODE_W | Current voltage code |
| status | output | 2 | Sequencer status code |

## Verification
The assertions check the following on every cycle:
- the step ordering invariants: voltage settled before an upward clock step, and ratio not above target during a voltage step;
- the exclusivity of the two requests;
- the link between the stall and the clock step;
- the stability of the sequence target while busy.

The following can only be shown by the bench's scenarios, because they need end-to-end knowledge of which point should be reached:
- the thermal arbitration outcomes (deferral, direct application, return after the event);
- the lowest-ratio floor;
- pickup of a goal changed mid-sequence.

// File: rtl/vfs_pkg.sv
package vfs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_VSTEP = 2'd1,
        ST_FSTEP = 2'd2
    } seq_state_e;

    localparam logic [1:0] STAT_IDLE  = 2'd0;
    localparam logic [1:0] STAT_VSTEP = 2'd1;
    localparam logic [1:0] STAT_FSTEP = 2'd2;
    localparam logic [1:0] STAT_DEFER = 2'd3;

endpackage

// File: rtl/vfs_goal_sel.sv
module vfs_goal_sel #(
    parameter int unsigned RATIO_W   = 8,
    parameter int unsigned VCODE_W   = 8,
    parameter logic [RATIO_W-1:0] RST_RATIO = 20,
    parameter logic [VCODE_W-1:0] RST_VCODE = 60,
    parameter logic [RATIO_W-1:0] LFM_RATIO = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               thermal_active,
    input  logic               thr_valid,
    input  logic [RATIO_W-1:0] thr_ratio,
    input  logic [VCODE_W-1:0] thr_vcode,
    input  logic               sw_valid,
    input  logic [RATIO_W-1:0] sw_ratio,
    input  logic [VCODE_W-1:0] sw_vcode,
    output logic [RATIO_W-1:0] goal_ratio,
    output logic [VCODE_W-1:0] goal_vcode,
    output logic               deferred
);

    typedef struct packed {
        logic [RATIO_W-1:0] nrm_r;
        logic [VCODE_W-1:0] nrm_v;
        logic [RATIO_W-1:0] thr_r;
        logic [VCODE_W-1:0] thr_v;
    } req_regs_t;

    req_regs_t req_d, req_q;
    logic [RATIO_W-1:0] thr_floor;

    always_comb begin
        req_d = req_q;
        if (sw_valid) begin
            req_d.nrm_r = sw_ratio;
            req_d.nrm_v = sw_vcode;
        end
        if (thr_valid) begin
            req_d.thr_r = thr_ratio;
            req_d.thr_v = thr_vcode;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q <= '{nrm_r: RST_RATIO, nrm_v: RST_VCODE,
                       thr_r: RST_RATIO, thr_v: RST_VCODE};
        end else begin
            req_q <= req_d;
        end
    end

    // Thermal ratio never pushed below the lowest-frequency ratio
    always_comb begin
        thr_floor = (req_q.thr_r < LFM_RATIO) ? LFM_RATIO : req_q.thr_r;
        deferred  = thermal_active && (req_q.nrm_r > thr_floor);
        if (deferred) begin
            goal_ratio = thr_floor;
            goal_vcode = req_q.thr_v;
        end else begin
            goal_ratio = req_q.nrm_r;
            goal_vcode = req_q.nrm_v;
        end
    end

endmodule

// File: rtl/vfs_step_fsm.sv
module vfs_step_fsm
    import vfs_pkg::*;
#(
    parameter int unsigned RATIO_W   = 8,
    parameter int unsigned VCODE_W   = 8,
    parameter logic [RATIO_W-1:0] RST_RATIO = 20,
    parameter logic [VCODE_W-1:0] RST_VCODE = 60
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [RATIO_W-1:0] goal_ratio,
    input  logic [VCODE_W-1:0] goal_vcode,
    input  logic               vr_ack,
    input  logic               clk_ack,
    output seq_state_e         state,
    output logic [RATIO_W-1:0] seq_ratio,
    output logic [VCODE_W-1:0] seq_vcode,
    output logic [RATIO_W-1:0] cur_ratio,
    output logic [VCODE_W-1:0] cur_vcode
);

    typedef struct packed {
        seq_state_e         st;
        logic [RATIO_W-1:0] seq_r;
        logic [VCODE_W-1:0] seq_v;
        logic [RATIO_W-1:0] cur_r;
        logic [VCODE_W-1:0] cur_v;
    } fsm_regs_t;

    fsm_regs_t fsm_d, fsm_q;

    always_comb begin
        fsm_d = fsm_q;
        unique case (fsm_q.st)
            ST_IDLE: begin
                fsm_d.seq_r = goal_ratio;
                fsm_d.seq_v = goal_vcode;
                if (goal_ratio > fsm_q.cur_r) begin
                    // upward: voltage leads when it must change
                    fsm_d.st = (goal_vcode != fsm_q.cur_v) ? ST_VSTEP : ST_FSTEP;
                end else if (goal_ratio < fsm_q.cur_r) begin
                    // downward: clock leads
                    fsm_d.st = ST_FSTEP;
                end else if (goal_vcode != fsm_q.cur_v) begin
                    fsm_d.st = ST_VSTEP;
                end
            end
            ST_VSTEP: begin
                if (vr_ack) begin
                    fsm_d.cur_v = fsm_q.seq_v;
                    fsm_d.st    = (fsm_q.seq_r != fsm_q.cur_r) ? ST_FSTEP : ST_IDLE;
                end
            end
            ST_FSTEP: begin
                if (clk_ack) begin
                    fsm_d.cur_r = fsm_q.seq_r;
                    fsm_d.st    = (fsm_q.seq_v != fsm_q.cur_v) ? ST_VSTEP : ST_IDLE;
                end
            end
            default: fsm_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsm_q <= '{st: ST_IDLE, seq_r: RST_RATIO, seq_v: RST_VCODE,
                       cur_r: RST_RATIO, cur_v: RST_VCODE};
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign state     = fsm_q.st;
    assign seq_ratio = fsm_q.seq_r;
    assign seq_vcode = fsm_q.seq_v;
    assign cur_ratio = fsm_q.cur_r;
    assign cur_vcode = fsm_q.cur_v;

endmodule

// File: rtl/vf_step_sequencer.sv
module vf_step_sequencer
    import vfs_pkg::*;
#(
    parameter int unsigned RATIO_W   = 8,
    parameter int unsigned VCODE_W   = 8,
    parameter logic [RATIO_W-1:0] RST_RATIO = 20,
    parameter logic [VCODE_W-1:0] RST_VCODE = 60,
    parameter logic [RATIO_W-1:0] LFM_RATIO = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               thermal_active,
    input  logic               thr_valid,
    input  logic [RATIO_W-1:0] thr_ratio,
    input  logic [VCODE_W-1:0] thr_vcode,
    input  logic               sw_valid,
    input  logic [RATIO_W-1:0] sw_ratio,
    input  logic [VCODE_W-1:0] sw_vcode,
    output logic               vr_req,
    output logic [VCODE_W-1:0] vr_code,
    input  logic               vr_ack,
    output logic               clk_req,
    output logic [RATIO_W-1:0] clk_ratio,
    input  logic               clk_ack,
    output logic               exec_halt,
    output logic [RATIO_W-1:0] cur_ratio,
    output logic [VCODE_W-1:0] cur_vcode,
    output logic [1:0]         status
);

    logic [RATIO_W-1:0] goal_ratio;
    logic [VCODE_W-1:0] goal_vcode;
    logic               deferred;
    seq_state_e         state;

    vfs_goal_sel #(
        .RATIO_W(RATIO_W), .VCODE_W(VCODE_W),
        .RST_RATIO(RST_RATIO), .RST_VCODE(RST_VCODE), .LFM_RATIO(LFM_RATIO)
    ) u_goal (
        .clk(clk), .rst_n(rst_n), .thermal_active(thermal_active),
        .thr_valid(thr_valid), .thr_ratio(thr_ratio), .thr_vcode(thr_vcode),
        .sw_valid(sw_valid), .sw_ratio(sw_ratio), .sw_vcode(sw_vcode),
        .goal_ratio(goal_ratio), .goal_vcode(goal_vcode), .deferred(deferred)
    );

    vfs_step_fsm #(
        .RATIO_W(RATIO_W), .VCODE_W(VCODE_W),
        .RST_RATIO(RST_RATIO), .RST_VCODE(RST_VCODE)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .goal_ratio(goal_ratio), .goal_vcode(goal_vcode),
        .vr_ack(vr_ack), .clk_ack(clk_ack),
        .state(state), .seq_ratio(clk_ratio), .seq_vcode(vr_code),
        .cur_ratio(cur_ratio), .cur_vcode(cur_vcode)
    );

    always_comb begin
        vr_req    = (state == ST_VSTEP);
        clk_req   = (state == ST_FSTEP);
        exec_halt = (state == ST_FSTEP);
        unique case (state)
            ST_VSTEP: status = STAT_VSTEP;
            ST_FSTEP: status = STAT_FSTEP;
            default:  status = deferred ? STAT_DEFER : STAT_IDLE;
        endcase
    end

endmodule

// File: rtl/vf_step_sequencer_chk.sv
module vf_step_sequencer_chk #(
    parameter int unsigned RATIO_W = 8,
    parameter int unsigned VCODE_W = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               vr_req,
    input logic [VCODE_W-1:0] vr_code,
    input logic               clk_req,
    input logic [RATIO_W-1:0] clk_ratio,
    input logic               exec_halt,
    input logic [RATIO_W-1:0] cur_ratio,
    input logic [VCODE_W-1:0] cur_vcode,
    input logic [1:0]         status
);

    AST_UP_VOLT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_req && clk_ratio > cur_ratio) |-> (cur_vcode == vr_code)); // R1

    AST_DOWN_FREQ_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        vr_req |-> (cur_ratio <= clk_ratio)); // R2

    AST_HALT_ONLY_FSTEP: assert property (@(posedge clk) disable iff (!rst_n)
        exec_halt |-> (clk_req && status == 2'd2)); // R3

    AST_NO_HALT_VSTEP: assert property (@(posedge clk) disable iff (!rst_n)
        vr_req |-> !exec_halt); // R3

    AST_ONE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({vr_req, clk_req})); // R4

    AST_TARGET_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        ((vr_req || clk_req) && $past(vr_req || clk_req))
            |-> ($stable(clk_ratio) && $stable(vr_code))); // R9

    AST_VSTEP_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        vr_req |-> (status == 2'd1)); // R10

endmodule

bind vf_step_sequencer vf_step_sequencer_chk #(
    .RATIO_W(RATIO_W), .VCODE_W(VCODE_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .vr_req(vr_req), .vr_code(vr_code),
    .clk_req(clk_req), .clk_ratio(clk_ratio), .exec_halt(exec_halt),
    .cur_ratio(cur_ratio), .cur_vcode(cur_vcode), .status(status)
);

// File: tb/vf_step_sequencer_bench.sv
module vf_step_sequencer_bench;

    localparam int RW = 8;
    localparam int VW = 8;
    localparam logic [RW-1:0] LFM = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic thermal_active = 1'b0;
    logic thr_valid = 1'b0, sw_valid = 1'b0;
    logic [RW-1:0] thr_ratio = '0, sw_ratio = '0;
    logic [VW-1:0] thr_vcode = '0, sw_vcode = '0;
    logic vr_req, clk_req, exec_halt;
    logic vr_ack = 1'b0, clk_ack = 1'b0;
    logic [VW-1:0] vr_code, cur_vcode;
    logic [RW-1:0] clk_ratio, cur_ratio;
    logic [1:0] status;

    int checks = 0;
    int fails  = 0;
    bit hold_ack = 1'b0;
    bit done = 1'b0;

    // software and thermal points as the bench believes them
    logic [RW-1:0] m_sw_r = 20, m_th_r = 20;
    logic [VW-1:0] m_sw_v = 60, m_th_v = 60;

    always #4 clk = ~clk;

    vf_step_sequencer u_vf_step_sequencer (
        .clk(clk), .rst_n(rst_n), .thermal_active(thermal_active),
        .thr_valid(thr_valid), .thr_ratio(thr_ratio), .thr_vcode(thr_vcode),
        .sw_valid(sw_valid), .sw_ratio(sw_ratio), .sw_vcode(sw_vcode),
        .vr_req(vr_req), .vr_code(vr_code), .vr_ack(vr_ack),
        .clk_req(clk_req), .clk_ratio(clk_ratio), .clk_ack(clk_ack),
        .exec_halt(exec_halt), .cur_ratio(cur_ratio), .cur_vcode(cur_vcode),
        .status(status)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [RW-1:0] floor_r(input logic [RW-1:0] r);
        return (r < LFM) ? LFM : r;
    endfunction

    function automatic bit exp_defer(input bit th);
        return th && (m_sw_r > floor_r(m_th_r));
    endfunction

    function automatic logic [RW-1:0] exp_r(input bit th);
        return exp_defer(th) ? floor_r(m_th_r) : m_sw_r;
    endfunction

    function automatic logic [VW-1:0] exp_v(input bit th);
        return exp_defer(th) ? m_th_v : m_sw_v;
    endfunction

    // acknowledge responders with random latency
    initial begin
        int vcnt = -1;
        int fcnt = -1;
        forever begin
            @(negedge clk);
            vr_ack  = 1'b0;
            clk_ack = 1'b0;
            if (vr_req && !hold_ack) begin
                if (vcnt < 0) vcnt = $urandom_range(0, 3);
                if (vcnt == 0) begin vr_ack = 1'b1; vcnt = -1; end
                else vcnt--;
            end else vcnt = -1;
            if (clk_req && !hold_ack) begin
                if (fcnt < 0) fcnt = $urandom_range(0, 3);
                if (fcnt == 0) begin clk_ack = 1'b1; fcnt = -1; end
                else fcnt--;
            end else fcnt = -1;
        end
    end

    // ordering monitor, checked on every busy cycle
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && clk_req && clk_ratio > cur_ratio)
                chk(cur_vcode == vr_code, "R1 voltage before upward clock step", cur_vcode, vr_code);
            if (rst_n && vr_req)
                chk(cur_ratio <= clk_ratio, "R2 clock before downward voltage step", cur_ratio, clk_ratio);
            if (rst_n && (vr_req || clk_req))
                chk(exec_halt == clk_req, "R3 halt only during clock step", exec_halt, clk_req);
        end
    end

    task automatic set_sw(input logic [RW-1:0] r, input logic [VW-1:0] v);
        @(negedge clk);
        sw_valid = 1'b1; sw_ratio = r; sw_vcode = v;
        m_sw_r = r; m_sw_v = v;
        @(negedge clk);
        sw_valid = 1'b0;
    endtask

    task automatic set_thr(input logic [RW-1:0] r, input logic [VW-1:0] v);
        @(negedge clk);
        thr_valid = 1'b1; thr_ratio = r; thr_vcode = v;
        m_th_r = r; m_th_v = v;
        @(negedge clk);
        thr_valid = 1'b0;
    endtask

    task automatic settle();
        int quiet = 0;
        int n = 0;
        repeat (2) @(negedge clk);
        while (quiet < 3 && n < 400) begin
            @(negedge clk);
            n++;
            if (!vr_req && !clk_req) quiet++;
            else quiet = 0;
        end
        if (quiet < 3) chk(1'b0, "R4 sequence did not complete", n, 0);
    endtask

    task automatic check_point(input string tag);
        chk(cur_ratio == exp_r(thermal_active), {tag, " ratio"}, cur_ratio, exp_r(thermal_active));
        chk(cur_vcode == exp_v(thermal_active), {tag, " vcode"}, cur_vcode, exp_v(thermal_active));
        chk(status == (exp_defer(thermal_active) ? 2'd3 : 2'd0), {tag, " status"},
            status, exp_defer(thermal_active) ? 3 : 0);
    endtask

    initial begin
        #1600000;
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R11 reset state
        chk(cur_ratio == 20, "R11 reset ratio", cur_ratio, 20);
        chk(cur_vcode == 60, "R11 reset vcode", cur_vcode, 60);
        chk(!vr_req && !clk_req && !exec_halt, "R11 no request", vr_req | clk_req, 0);
        chk(status == 2'd0, "R11 status", status, 0);
        rst_n = 1'b1;

        // R1 upward, R10 voltage-step status while ack held
        hold_ack = 1'b1;
        set_sw(30, 80);
        repeat (3) @(negedge clk);
        chk(vr_req && !clk_req, "R1 voltage step first on rise", vr_req, 1);
        chk(status == 2'd1, "R10 status during voltage step", status, 1);
        repeat (10) @(negedge clk);
        chk(vr_req && cur_vcode == 60, "R4 held until acknowledge", cur_vcode, 60);
        hold_ack = 1'b0;
        settle();
        check_point("R1 upward settle");

        // R2 downward, R3/R10 clock-step status while ack held
        hold_ack = 1'b1;
        set_sw(12, 40);
        repeat (3) @(negedge clk);
        chk(clk_req && !vr_req, "R2 clock step first on fall", clk_req, 1);
        chk(exec_halt == 1'b1, "R3 halt during clock step", exec_halt, 1);
        chk(status == 2'd2, "R10 status during clock step", status, 2);
        hold_ack = 1'b0;
        settle();
        check_point("R2 downward settle");
        chk(exec_halt == 1'b0, "R3 no halt when idle", exec_halt, 0);

        // R9 goal changed mid-sequence
        set_sw(40, 90);
        while (!vr_req) @(negedge clk);
        set_sw(15, 50);
        while (!clk_req) @(negedge clk);
        chk(clk_ratio == 40, "R9 latched target kept", clk_ratio, 40);
        settle();
        check_point("R9 new goal after sequence");

        // R5 + R8: software high, thermal below floor
        set_sw(36, 88);
        set_thr(3, 30);
        @(negedge clk); thermal_active = 1'b1;
        settle();
        check_point("R5 R8 deferred at floored thermal point");
        chk(cur_ratio == LFM, "R8 floored ratio", cur_ratio, LFM);

        // R6 software below thermal target applied
        set_thr(25, 70);
        set_sw(18, 52);
        settle();
        check_point("R6 lower software request applied");

        // R5 again then R7 release
        set_sw(44, 95);
        settle();
        check_point("R5 higher software request deferred");
        @(negedge clk); thermal_active = 1'b0;
        settle();
        check_point("R7 return to software point");

        // random mix
        for (int i = 0; i < 40; i++) begin
            int kind = $urandom_range(0, 2);
            if (kind == 0) set_sw(RW'($urandom_range(4, 60)), VW'($urandom_range(20, 120)));
            else if (kind == 1) set_thr(RW'($urandom_range(1, 50)), VW'($urandom_range(20, 120)));
            else begin @(negedge clk); thermal_active = ~thermal_active; end
            settle();
            check_point("R5 R6 R7 R8 random");
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule